// File: doc/BRIEF.md
# Instruction Length Decoder

This block takes a window of raw instruction bytes, already aligned so that window byte 0 is the first byte of an instruction, and works out where that instruction ends. It walks the bytes strictly in address order. It first skips any legacy prefixes and an optional REX byte. It then classifies the one- or two-byte opcode, which settles whether a ModRM byte and an immediate follow. The ModRM byte, and the SIB byte when there is one, settle the displacement size.

For each accepted window the block reports the following, one clock cycle later:
- the total length;
- a presence flag and a byte offset for every field;
- the displacement and the immediate, rebuilt from their little-endian bytes and sign-extended to 64 bits.

An instruction whose opcode lies outside the supported subset is flagged illegal instead of getting a length. So is an instruction longer than 15 bytes, or a window made only of prefixes. A fetch unit uses the reported length to advance its pointer to the next instruction. It can deliver one window per cycle.

Top module: `insn_len_decoder`

## Requirements
- R1: Window byte i sits at `in_window[8*i+7:8*i]`, and byte 0 is the lowest address. Bytes are consumed in address order with no regrouping into words. For example, 10 1A is a 2-byte instruction: opcode 0x10 at offset 0, and ModRM 0x1A (mod=00, rm=010) at offset 1 with no displacement.
- R2: Displacement and immediate bytes are assembled least significant byte first. Any field shorter than 8 bytes is sign-extended to 64 bits from its top byte. For example, 81 C1 78 56 34 12 gives the immediate 0x12345678.
- R3: The legacy prefixes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3 are accepted in any order and any number. Their count is reported, and the opcode offset equals the number of bytes before the opcode.
- R4: A byte 0x40–0x4F counts as REX only when it is the last byte before the opcode, and its bit 3 is W. A REX followed by a legacy prefix is counted in the length but reported as absent, and its W bit is dropped.
- R5: The prefix 0x66, without REX.W, shrinks a full-size immediate (opcodes 0x05-style ALU forms, 0x68, 0x69, 0x81, 0xC7) from 4 bytes to 2.
- R6: With REX.W, the opcodes 0xB8–0xBF take an 8-byte immediate, and REX.W takes priority over 0x66. With REX.W, 0x81 keeps a 4-byte immediate sign-extended to 64 bits: 48 81 87 34 12 00 00 DD CC BB AA is 11 bytes, with displacement 0x1234 and immediate 0xFFFFFFFFAABBCCDD.
- R7: The ModRM mod field (bits 7:6) selects the displacement: 11 gives none, 01 gives 1 byte, 10 gives 4 bytes, and 00 gives none except for rm=101, which gives 4 bytes.
- R8: When mod≠11 and rm (bits 2:0) = 100, a SIB byte follows the ModRM byte. When mod=00 and the SIB base (bits 2:0) = 101, a 4-byte displacement follows the SIB byte.
- R9: Opcode byte 0x0F escapes to a two-byte opcode. Prefixes that select a different two-byte instruction (for example F3 0F 58 C1) are still counted, so that example is 4 bytes. The two-byte forms 0x0F 0x80–0x8F take a 4-byte immediate.
- R10: An unsupported opcode (for example 0x06, or 0x0F 0xFF) raises illegal, gives length 0 and clears every field flag.
- R11: A computed length above 15 raises illegal, and so does a window with no opcode in it. A length of exactly 15 is legal.
- R12: Results appear on the outputs one cycle after a clock edge with `in_valid` high, together with `out_valid`. Without `in_valid` the outputs hold and `out_valid` is low. Reset clears `out_valid` and every output.
- R13: The supported one-byte opcodes are:
  - 0x00–0x3F with low three bits 0–3: ModRM.
  - 0x00–0x3F with low three bits 4: imm8.
  - 0x00–0x3F with low three bits 5: full-size immediate.
  - 0x50–0x5F, 0x90–0x99, 0xC3, 0xCC, 0xF4: no operand bytes.
  - 0x63, 0x84–0x8B, 0x8D, 0x8F, 0xFF: ModRM.
  - 0x68 and 0xC7: full-size immediate, with ModRM for 0xC7.
  - 0x69 and 0x81: ModRM plus full-size immediate.
  - 0x6A, 0x70–0x7F, 0xB0–0xB7, 0xEB: imm8.
  - 0x6B, 0x80, 0x83, 0xC6: ModRM plus imm8.
  - 0xE8 and 0xE9: 4-byte immediate.

  The supported two-byte opcodes, after 0x0F, are:
  - 0x05 and 0x0B: no operand bytes.
  - 0x10, 0x11, 0x1F, 0x28, 0x29, 0x50–0x5F, 0xAF, 0xB6, 0xB7: ModRM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window is present this cycle |
| in_window | input | 8*WIN_BYTES | Instruction bytes, byte 0 in bits 7:0 |
| out_valid | output | 1 | Result registers hold a new result |
| out_illegal | output | 1 | Instruction not decodable |
| out_len | output | LEN_W | Instruction length in bytes (0 when illegal) |
| out_has_legacy | output | 1 | At least one legacy prefix seen |
| out_pfx_count | output | LEN_W | Bytes before the opcode |
| out_has_rex | output | 1 | REX directly before the opcode |
| out_rex_w | output | 1 | REX.W in effect |
| out_two_byte | output | 1 | Opcode uses the 0x0F escape |
| out_opcode_ofs | output | LEN_W | Offset of the first opcode byte |
| out_has_modrm | output | 1 | ModRM byte present |
| out_modrm_ofs | output | LEN_W | Offset of ModRM |
| out_has_sib | output | 1 | SIB byte present |
| out_sib_ofs | output | LEN_W | Offset of SIB |
| out_disp_len | output | 4 | Displacement bytes (0, 1 or 4) |
| out_disp_ofs | output | LEN_W | Offset of the displacement |
| out_disp | output | 64 | Sign-extended displacement |
| out_imm_len | output | 4 | Immediate bytes (0, 1, 2, 4 or 8) |
| out_imm_ofs | output | LEN_W | Offset of the immediate |
| out_imm | output | 64 | Sign-extended immediate |

## Verification
The hardest case to reach is a length overflow on an instruction that is otherwise well formed. Every field must be legal on its own, and only their sum may exceed 15. The stimulus builds it from a run of eleven segment-override prefixes ahead of a 0x81 form that carries both a 4-byte displacement and a 4-byte immediate. Beside it sits a 15-byte case that must still pass. A REX byte that is not adjacent to the opcode is also easy to miss. It is reached by placing 0x66 after 0x48 and checking that the REX flag drops while the length still counts both bytes.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int ILD_WIN_BYTES = 16;
    localparam int ILD_MAX_LEN   = 15;
    localparam int VAL_W         = 64;

    typedef enum logic [2:0] {
        IMM_NONE,
        IMM_BYTE,
        IMM_FULL,
        IMM_DWORD,
        IMM_WIDE
    } imm_kind_e;

    typedef struct packed {
        logic      legal;
        logic      has_modrm;
        imm_kind_e imm;
    } op_class_t;

    typedef struct packed {
        logic found;
        logic has_legacy;
        logic opd16;
        logic has_rex;
        logic rex_w;
    } pfx_flags_t;

    typedef struct packed {
        logic       has_sib;
        logic [3:0] disp_len;
    } mrm_info_t;

    function automatic logic is_legacy_pfx(input logic [7:0] b);
        case (b)
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
            8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    function automatic logic is_rex(input logic [7:0] b);
        return b[7:4] == 4'h4;
    endfunction

    function automatic logic [3:0] imm_bytes(input imm_kind_e k,
                                             input logic opd16,
                                             input logic rex_w);
        case (k)
            IMM_BYTE:  return 4'd1;
            IMM_FULL:  return (opd16 && !rex_w) ? 4'd2 : 4'd4;
            IMM_DWORD: return 4'd4;
            IMM_WIDE:  return rex_w ? 4'd8 : (opd16 ? 4'd2 : 4'd4);
            default:   return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/ild_prefix_scan.sv
module ild_prefix_scan
    import ild_pkg::*;
#(
    parameter int WIN_BYTES = ILD_WIN_BYTES,
    parameter int OFS_W     = 5
)(
    input  logic [8*WIN_BYTES-1:0] window,
    output pfx_flags_t             flags,
    output logic [OFS_W-1:0]       count
);

    logic stop;

    always_comb begin
        flags = '0;
        count = '0;
        stop  = 1'b0;
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (!stop) begin
                if (is_legacy_pfx(window[8*i +: 8])) begin
                    count            = OFS_W'(i + 1);
                    flags.has_legacy = 1'b1;
                    if (window[8*i +: 8] == 8'h66)
                        flags.opd16 = 1'b1;
                    // a REX that is not adjacent to the opcode is void
                    flags.has_rex = 1'b0;
                    flags.rex_w   = 1'b0;
                end else if (is_rex(window[8*i +: 8])) begin
                    count         = OFS_W'(i + 1);
                    flags.has_rex = 1'b1;
                    flags.rex_w   = window[8*i + 3];
                end else begin
                    stop        = 1'b1;
                    flags.found = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ild_opcode_class.sv
module ild_opcode_class
    import ild_pkg::*;
(
    input  logic [7:0] op0,
    input  logic [7:0] op1,
    output op_class_t  cls,
    output logic       two_byte
);

    always_comb begin
        cls      = '{legal: 1'b0, has_modrm: 1'b0, imm: IMM_NONE};
        two_byte = (op0 == 8'h0F);
        if (two_byte) begin
            casez (op1)
                8'h05, 8'h0B:
                    cls.legal = 1'b1;
                8'h10, 8'h11, 8'h1F, 8'h28, 8'h29, 8'hAF, 8'hB6, 8'hB7,
                8'b0101_????:
                    cls = '{legal: 1'b1, has_modrm: 1'b1, imm: IMM_NONE};
                8'b1000_????:
                    cls = '{legal: 1'b1, has_modrm: 1'b0, imm: IMM_DWORD};
                default:
                    cls.legal = 1'b0;
            endcase
        end else begin
            casez (op0)
                8'b00??_?0??, 8'h63, 8'b1000_01??, 8'b1000_10??,
                8'h8D, 8'h8F, 8'hFF:
                    cls = '{legal: 1'b1, has_modrm: 1'b1, imm: IMM_NONE};
                8'b00??_?100, 8'h6A, 8'b0111_????, 8'b1011_0???, 8'hEB:
                    cls = '{legal: 1'b1, has_modrm: 1'b0, imm: IMM_BYTE};
                8'b00??_?101, 8'h68:
                    cls = '{legal: 1'b1, has_modrm: 1'b0, imm: IMM_FULL};
                8'h69, 8'h81, 8'hC7:
                    cls = '{legal: 1'b1, has_modrm: 1'b1, imm: IMM_FULL};
                8'h6B, 8'h80, 8'h83, 8'hC6:
                    cls = '{legal: 1'b1, has_modrm: 1'b1, imm: IMM_BYTE};
                8'b1011_1???:
                    cls = '{legal: 1'b1, has_modrm: 1'b0, imm: IMM_WIDE};
                8'hE8, 8'hE9:
                    cls = '{legal: 1'b1, has_modrm: 1'b0, imm: IMM_DWORD};
                8'b0101_????, 8'b1001_0???, 8'h98, 8'h99,
                8'hC3, 8'hCC, 8'hF4:
                    cls = '{legal: 1'b1, has_modrm: 1'b0, imm: IMM_NONE};
                default:
                    cls.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ild_modrm_decode.sv
module ild_modrm_decode
    import ild_pkg::*;
(
    input  logic [7:0] modrm,
    input  logic [7:0] sib,
    output mrm_info_t  info
);

    logic [1:0] mode;
    logic [2:0] rm;

    assign mode = modrm[7:6];
    assign rm   = modrm[2:0];

    always_comb begin
        info.has_sib = (mode != 2'b11) && (rm == 3'b100);
        case (mode)
            2'b01:   info.disp_len = 4'd1;
            2'b10:   info.disp_len = 4'd4;
            2'b00: begin
                if (rm == 3'b101)
                    info.disp_len = 4'd4;
                else if (rm == 3'b100 && sib[2:0] == 3'b101)
                    info.disp_len = 4'd4;
                else
                    info.disp_len = 4'd0;
            end
            default: info.disp_len = 4'd0;
        endcase
    end

endmodule

// File: rtl/ild_field_extract.sv
module ild_field_extract #(
    parameter int WIN_BYTES = 16,
    parameter int OFS_W     = 5,
    parameter int VAL_W     = 64
)(
    input  logic [8*WIN_BYTES-1:0] window,
    input  logic [OFS_W-1:0]       ofs,
    input  logic [3:0]             nbytes,
    output logic [VAL_W-1:0]       value
);

    localparam int LANES = VAL_W / 8;

    logic [8*WIN_BYTES-1:0] shifted;
    logic                   sign;

    assign shifted = window >> {ofs, 3'b000};

    always_comb begin
        sign = 1'b0;
        for (int k = 0; k < LANES; k++)
            if (k + 1 == int'(nbytes))
                sign = shifted[8*k + 7];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign value[8*k +: 8] = (k < int'(nbytes)) ? shifted[8*k +: 8]
                                                   : {8{sign}};
    end

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
    import ild_pkg::*;
#(
    parameter  int WIN_BYTES = ILD_WIN_BYTES,
    parameter  int MAX_LEN   = ILD_MAX_LEN,
    localparam int WIN_W     = 8 * WIN_BYTES,
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIN_W-1:0] in_window,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [LEN_W-1:0] out_len,
    output logic             out_has_legacy,
    output logic [LEN_W-1:0] out_pfx_count,
    output logic             out_has_rex,
    output logic             out_rex_w,
    output logic             out_two_byte,
    output logic [LEN_W-1:0] out_opcode_ofs,
    output logic             out_has_modrm,
    output logic [LEN_W-1:0] out_modrm_ofs,
    output logic             out_has_sib,
    output logic [LEN_W-1:0] out_sib_ofs,
    output logic [3:0]       out_disp_len,
    output logic [LEN_W-1:0] out_disp_ofs,
    output logic [VAL_W-1:0] out_disp,
    output logic [3:0]       out_imm_len,
    output logic [LEN_W-1:0] out_imm_ofs,
    output logic [VAL_W-1:0] out_imm
);

    // wide enough for the longest chain of fields past the last window byte
    localparam int OFS_W = $clog2(WIN_BYTES + 16);

    function automatic logic [7:0] byte_at(input logic [OFS_W-1:0] idx);
        logic [WIN_W-1:0] s;
        s = in_window >> {idx, 3'b000};
        return s[7:0];
    endfunction

    pfx_flags_t       pfx;
    logic [OFS_W-1:0] pfx_cnt;
    op_class_t        cls;
    logic             two_byte;
    mrm_info_t        mrm;
    logic [7:0]       op0, op1, modrm_b, sib_b;
    logic [OFS_W-1:0] modrm_ofs, after_modrm, disp_ofs, imm_ofs, total;
    logic [3:0]       disp_len, imm_len;
    logic             has_sib, illegal, ok;
    logic [VAL_W-1:0] disp_val, imm_val;

    ild_prefix_scan #(.WIN_BYTES(WIN_BYTES), .OFS_W(OFS_W)) u_pfx (
        .window (in_window),
        .flags  (pfx),
        .count  (pfx_cnt)
    );

    assign op0 = byte_at(pfx_cnt);
    assign op1 = byte_at(pfx_cnt + OFS_W'(1));

    ild_opcode_class u_opc (
        .op0      (op0),
        .op1      (op1),
        .cls      (cls),
        .two_byte (two_byte)
    );

    assign modrm_ofs = pfx_cnt + (two_byte ? OFS_W'(2) : OFS_W'(1));
    assign modrm_b   = byte_at(modrm_ofs);
    assign sib_b     = byte_at(modrm_ofs + OFS_W'(1));

    ild_modrm_decode u_mrm (
        .modrm (modrm_b),
        .sib   (sib_b),
        .info  (mrm)
    );

    assign has_sib     = cls.has_modrm & mrm.has_sib;
    assign after_modrm = modrm_ofs + OFS_W'(cls.has_modrm);
    assign disp_len    = cls.has_modrm ? mrm.disp_len : 4'd0;
    assign disp_ofs    = after_modrm + OFS_W'(has_sib);
    assign imm_len     = imm_bytes(cls.imm, pfx.opd16, pfx.rex_w);
    assign imm_ofs     = disp_ofs + OFS_W'(disp_len);
    assign total       = imm_ofs + OFS_W'(imm_len);

    assign illegal = !pfx.found || !cls.legal || (int'(total) > MAX_LEN);
    assign ok      = !illegal;

    ild_field_extract #(.WIN_BYTES(WIN_BYTES), .OFS_W(OFS_W), .VAL_W(VAL_W)) u_disp (
        .window (in_window),
        .ofs    (disp_ofs),
        .nbytes (disp_len),
        .value  (disp_val)
    );

    ild_field_extract #(.WIN_BYTES(WIN_BYTES), .OFS_W(OFS_W), .VAL_W(VAL_W)) u_imm (
        .window (in_window),
        .ofs    (imm_ofs),
        .nbytes (imm_len),
        .value  (imm_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_illegal    <= 1'b0;
            out_len        <= '0;
            out_has_legacy <= 1'b0;
            out_pfx_count  <= '0;
            out_has_rex    <= 1'b0;
            out_rex_w      <= 1'b0;
            out_two_byte   <= 1'b0;
            out_opcode_ofs <= '0;
            out_has_modrm  <= 1'b0;
            out_modrm_ofs  <= '0;
            out_has_sib    <= 1'b0;
            out_sib_ofs    <= '0;
            out_disp_len   <= '0;
            out_disp_ofs   <= '0;
            out_disp       <= '0;
            out_imm_len    <= '0;
            out_imm_ofs    <= '0;
            out_imm        <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal    <= illegal;
                out_len        <= ok ? LEN_W'(total) : '0;
                out_has_legacy <= ok & pfx.has_legacy;
                out_pfx_count  <= ok ? LEN_W'(pfx_cnt) : '0;
                out_has_rex    <= ok & pfx.has_rex;
                out_rex_w      <= ok & pfx.rex_w;
                out_two_byte   <= ok & two_byte;
                out_opcode_ofs <= ok ? LEN_W'(pfx_cnt) : '0;
                out_has_modrm  <= ok & cls.has_modrm;
                out_modrm_ofs  <= (ok && cls.has_modrm) ? LEN_W'(modrm_ofs) : '0;
                out_has_sib    <= ok & has_sib;
                out_sib_ofs    <= (ok && has_sib) ? LEN_W'(after_modrm) : '0;
                out_disp_len   <= ok ? disp_len : 4'd0;
                out_disp_ofs   <= (ok && disp_len != 4'd0) ? LEN_W'(disp_ofs) : '0;
                out_disp       <= ok ? disp_val : '0;
                out_imm_len    <= ok ? imm_len : 4'd0;
                out_imm_ofs    <= (ok && imm_len != 4'd0) ? LEN_W'(imm_ofs) : '0;
                out_imm        <= ok ? imm_val : '0;
            end
        end
    end

endmodule

// File: rtl/insn_len_decoder_chk.sv
module insn_len_decoder_chk
    import ild_pkg::*;
#(
    parameter  int WIN_BYTES = ILD_WIN_BYTES,
    parameter  int MAX_LEN   = ILD_MAX_LEN,
    localparam int WIN_W     = 8 * WIN_BYTES,
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
)(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIN_W-1:0] in_window,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [LEN_W-1:0] out_len,
    input logic             out_has_legacy,
    input logic [LEN_W-1:0] out_pfx_count,
    input logic             out_has_rex,
    input logic             out_rex_w,
    input logic             out_two_byte,
    input logic [LEN_W-1:0] out_opcode_ofs,
    input logic             out_has_modrm,
    input logic [LEN_W-1:0] out_modrm_ofs,
    input logic             out_has_sib,
    input logic [LEN_W-1:0] out_sib_ofs,
    input logic [3:0]       out_disp_len,
    input logic [LEN_W-1:0] out_disp_ofs,
    input logic [VAL_W-1:0] out_disp,
    input logic [3:0]       out_imm_len,
    input logic [LEN_W-1:0] out_imm_ofs,
    input logic [VAL_W-1:0] out_imm
);

    // R10
    a_r10_illegal_no_len: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_len == '0 && !out_has_modrm && !out_has_sib));

    // R11
    a_r11_len_bound: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |-> (out_len != '0 && int'(out_len) <= MAX_LEN));

    // R12
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R12
    a_r12_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_len) && $stable(out_imm) && !out_valid));

    // R8
    a_r8_sib_after_modrm: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_has_sib) |->
            (out_has_modrm && int'(out_sib_ofs) == int'(out_modrm_ofs) + 1));

    // R2
    a_r2_disp8_sext: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_disp_len == 4'd1) |-> (out_disp[VAL_W-1:8] == {(VAL_W-8){out_disp[7]}}));

    // R7
    a_r7_disp_size: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_disp_len == 4'd0 || out_disp_len == 4'd1 || out_disp_len == 4'd4));

    // R5
    a_r5_imm_size: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_imm_len) <= 1));

    // R1
    a_r1_imm_ends_insn: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && out_imm_len != 4'd0) |->
            (int'(out_imm_ofs) + int'(out_imm_len) == int'(out_len)));

endmodule

bind insn_len_decoder insn_len_decoder_chk #(
    .WIN_BYTES (WIN_BYTES),
    .MAX_LEN   (MAX_LEN)
) u_chk (.*);

// File: tb/test_insn_len_decoder.sv
`timescale 1ns/1ps
module test_insn_len_decoder;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_window = '0;

    logic         out_valid, out_illegal;
    logic [3:0]   out_len, out_pfx_count, out_opcode_ofs, out_modrm_ofs;
    logic [3:0]   out_sib_ofs, out_disp_ofs, out_imm_ofs, out_disp_len, out_imm_len;
    logic         out_has_legacy, out_has_rex, out_rex_w, out_two_byte;
    logic         out_has_modrm, out_has_sib;
    logic [63:0]  out_disp, out_imm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    insn_len_decoder i_insn_len_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_window(in_window),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_len(out_len),
        .out_has_legacy(out_has_legacy), .out_pfx_count(out_pfx_count),
        .out_has_rex(out_has_rex), .out_rex_w(out_rex_w),
        .out_two_byte(out_two_byte), .out_opcode_ofs(out_opcode_ofs),
        .out_has_modrm(out_has_modrm), .out_modrm_ofs(out_modrm_ofs),
        .out_has_sib(out_has_sib), .out_sib_ofs(out_sib_ofs),
        .out_disp_len(out_disp_len), .out_disp_ofs(out_disp_ofs), .out_disp(out_disp),
        .out_imm_len(out_imm_len), .out_imm_ofs(out_imm_ofs), .out_imm(out_imm)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // seq holds n bytes, first byte most significant; rest of window is 0x90
    task automatic send(input logic [127:0] seq, input int n);
        @(negedge clk);
        for (int i = 0; i < 16; i++)
            in_window[8*i +: 8] = (i < n) ? seq[8*(n-1-i) +: 8] : 8'h90;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12", "valid in reset", 64'(out_valid), 64'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R12", "valid after reset", 64'(out_valid), 64'd0);
        chk("R12", "len after reset", 64'(out_len), 64'd0);
    endtask

    task automatic t_byte_stream;
        send(128'h101A, 2);
        chk("R1", "valid", 64'(out_valid), 64'd1);
        chk("R1", "len 10 1A", 64'(out_len), 64'd2);
        chk("R1", "opcode ofs", 64'(out_opcode_ofs), 64'd0);
        chk("R1", "modrm ofs", 64'(out_modrm_ofs), 64'd1);
        chk("R7", "no disp", 64'(out_disp_len), 64'd0);
    endtask

    task automatic t_imm32;
        send(128'h81C178563412, 6);
        chk("R2", "len", 64'(out_len), 64'd6);
        chk("R2", "imm le", out_imm, 64'h12345678);
        chk("R13", "imm ofs", 64'(out_imm_ofs), 64'd2);
        chk("R7", "mod11 no disp", 64'(out_disp_len), 64'd0);
    endtask

    task automatic t_rex_w;
        send(128'h48818734120000DDCCBBAA, 11);
        chk("R6", "len", 64'(out_len), 64'd11);
        chk("R4", "rex", 64'(out_has_rex), 64'd1);
        chk("R4", "rex w", 64'(out_rex_w), 64'd1);
        chk("R6", "disp", out_disp, 64'h1234);
        chk("R6", "disp ofs", 64'(out_disp_ofs), 64'd3);
        chk("R6", "imm sext", out_imm, 64'hFFFFFFFFAABBCCDD);
        chk("R6", "imm len", 64'(out_imm_len), 64'd4);
    endtask

    task automatic t_opsize;
        send(128'h6681C134F2, 5);
        chk("R5", "len", 64'(out_len), 64'd5);
        chk("R5", "imm len", 64'(out_imm_len), 64'd2);
        chk("R2", "imm16 sext", out_imm, 64'hFFFFFFFFFFFFF234);
        chk("R3", "pfx count", 64'(out_pfx_count), 64'd1);
    endtask

    task automatic t_wide_imm;
        send(128'h48B88877665544332211, 10);
        chk("R6", "movabs len", 64'(out_len), 64'd10);
        chk("R6", "imm64", out_imm, 64'h1122334455667788);
        send(128'hB878563412, 5);
        chk("R6", "no rex len", 64'(out_len), 64'd5);
        send(128'h6648B88877665544332211, 11);
        chk("R6", "rex.w over 66 len", 64'(out_len), 64'd11);
        chk("R6", "rex.w over 66 imm len", 64'(out_imm_len), 64'd8);
    endtask

    task automatic t_modrm_forms;
        send(128'h8B45F8, 3);
        chk("R7", "disp8 len", 64'(out_len), 64'd3);
        chk("R2", "disp8 sext", out_disp, 64'hFFFFFFFFFFFFFFF8);
        send(128'h8B8500010000, 6);
        chk("R7", "disp32 len", 64'(out_len), 64'd6);
        chk("R7", "disp32", out_disp, 64'h100);
        send(128'h8B0544332211, 6);
        chk("R7", "rm101 disp", out_disp, 64'h11223344);
        chk("R7", "rm101 disp len", 64'(out_disp_len), 64'd4);
    endtask

    task automatic t_sib;
        send(128'h8B0424, 3);
        chk("R8", "sib len", 64'(out_len), 64'd3);
        chk("R8", "sib flag", 64'(out_has_sib), 64'd1);
        chk("R8", "sib ofs", 64'(out_sib_ofs), 64'd2);
        send(128'h8B042578563412, 7);
        chk("R8", "base101 len", 64'(out_len), 64'd7);
        chk("R8", "base101 disp", out_disp, 64'h12345678);
        send(128'h8B442408, 4);
        chk("R8", "sib disp8 len", 64'(out_len), 64'd4);
        send(128'h8BC4, 2);
        chk("R8", "mod11 rm100 no sib", 64'(out_has_sib), 64'd0);
        chk("R8", "mod11 rm100 len", 64'(out_len), 64'd2);
    endtask

    task automatic t_prefix_order;
        send(128'h6567030424, 5);
        chk("R3", "two pfx len", 64'(out_len), 64'd5);
        chk("R3", "opcode ofs", 64'(out_opcode_ofs), 64'd2);
        chk("R3", "legacy flag", 64'(out_has_legacy), 64'd1);
        send(128'hF02E36F201C8, 6);
        chk("R3", "four pfx len", 64'(out_len), 64'd6);
        chk("R3", "four pfx count", 64'(out_pfx_count), 64'd4);
    endtask

    task automatic t_rex_position;
        send(128'h486601C8, 4);
        chk("R4", "void rex len", 64'(out_len), 64'd4);
        chk("R4", "void rex flag", 64'(out_has_rex), 64'd0);
        chk("R4", "void rex w", 64'(out_rex_w), 64'd0);
        chk("R4", "opcode ofs", 64'(out_opcode_ofs), 64'd2);
    endtask

    task automatic t_two_byte;
        send(128'hF30F58C1, 4);
        chk("R9", "mandatory pfx len", 64'(out_len), 64'd4);
        chk("R9", "two byte", 64'(out_two_byte), 64'd1);
        chk("R9", "modrm ofs", 64'(out_modrm_ofs), 64'd3);
        send(128'h0F8410000000, 6);
        chk("R9", "jcc32 len", 64'(out_len), 64'd6);
        chk("R9", "jcc32 imm", out_imm, 64'h10);
        send(128'h0F05, 2);
        chk("R9", "no operand len", 64'(out_len), 64'd2);
    endtask

    task automatic t_illegal;
        send(128'h06, 1);
        chk("R10", "illegal flag", 64'(out_illegal), 64'd1);
        chk("R10", "illegal len", 64'(out_len), 64'd0);
        send(128'h0FFF, 2);
        chk("R10", "0F FF illegal", 64'(out_illegal), 64'd1);
        chk("R10", "0F FF no modrm", 64'(out_has_modrm), 64'd0);
    endtask

    task automatic t_too_long;
        send(128'h2E2E2E2E2E2E2E2E2E2E2E8180000000, 16);
        chk("R11", "len 21 illegal", 64'(out_illegal), 64'd1);
        chk("R11", "len 21 zero", 64'(out_len), 64'd0);
        send(128'h2E2E2E2E48818734120000DDCCBBAA, 15);
        chk("R11", "len 15 legal", 64'(out_illegal), 64'd0);
        chk("R11", "len 15", 64'(out_len), 64'd15);
        send(128'h66666666666666666666666666666666, 16);
        chk("R11", "no opcode illegal", 64'(out_illegal), 64'd1);
    endtask

    task automatic t_idle_hold;
        send(128'h8B45F8, 3);
        @(negedge clk);
        chk("R12", "idle valid low", 64'(out_valid), 64'd0);
        chk("R12", "idle len held", 64'(out_len), 64'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_byte_stream();
        t_imm32();
        t_rex_w();
        t_opsize();
        t_wide_imm();
        t_modrm_forms();
        t_sib();
        t_prefix_order();
        t_rex_position();
        t_two_byte();
        t_illegal();
        t_too_long();
        t_idle_hold();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (R12): actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule